// File: doc/BRIEF.md
# Video Line Blanking Generator

This block follows the line and field timing of a video stream from two active-low sync inputs. Both inputs are sampled on the pixel clock. It keeps a line count within the frame and works out whether the current field is odd or even. It raises an internal vertical blanking flag over fixed line windows. The window set follows the selected standard, either 525-line or 625-line. The block then merges that flag with a per-pixel active-low external blank to produce one display-enable signal.

Only the falling (leading) edge of horizontal sync carries timing. Each leading edge starts a back-porch interval whose length is set by a parameter, and display stays off until that interval ends. The standard-select input is taken only when a new frame begins, so the blanking windows stay fixed for the whole frame.

Top module: `vid_blank_gen`

## Requirements
- R1: `ext_blank_n` is registered on the rising clock edge. A low level drives `disp_en` low two clock edges after it is applied, one pixel at a time. A high level lets display resume on the same two-edge delay.
- R2: `disp_en` is high only when three conditions hold together: internal vertical blanking is inactive, the back porch has expired and the external blank is high. `disp_en` and `vblank` are never high together.
- R3: With `pal_mode`=0 (525-line), `vblank` is high on lines 1–20, 263–283 and 525, and low on all other lines from 1 to 525.
- R4: With `pal_mode`=1 (625-line), `vblank` is high on lines 1–23, 310–335 and 623–625, and low on all other lines from 1 to 625.
- R5: Only the leading edge of `hsync_n` is used. The low width of the pulse and its rising edge have no effect on the line count or on display timing.
- R6: Take the edge at which a falling `hsync_n` is first sampled as edge 0. `disp_en` is low after edges 1 through BP_CLKS+1. It can go high again after edge BP_CLKS+2.
- R7: `line_num` becomes 1 on the first `hsync_n` leading edge at or after a `vsync_n` leading edge. It then increases by 1 on each later `hsync_n` leading edge. It changes on no other cycle and stays at 0 until the first frame start.
- R8: `field_odd` becomes 1 if `hsync_n` is sampled low on the cycle where the `vsync_n` leading edge is detected, and 0 otherwise. It changes on no other cycle.
- R9: `pal_mode` is captured only when `line_num` restarts at 1. A change during a frame leaves that frame's blanking windows unchanged.
- R10: After reset, `disp_en`=0, `field_odd`=0 and `line_num`=0. Before the first frame start every line is treated as blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| ext_blank_n | input | 1 | External per-pixel blank, active low |
| pal_mode | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| field_odd | output | 1 | Field parity of the current frame |
| line_num | output | LINE_W | Line number within the frame (0 = not yet locked) |
| vblank | output | 1 | Internal vertical blanking flag |
| disp_en | output | 1 | Final display enable |

## Verification
The assertions check on every cycle that the line count, field flag and captured standard hold steady except on their own update events. They also check that a sync leading edge always blanks the next cycle, that a low external blank always blanks `disp_en`, and that `vblank` and `disp_en` are never high together. The exact window boundaries for both standards, the back-porch length and the field parity of whole frames can only be shown by the bench. It sweeps every line of odd and even frames in both standards, varies the sync pulse width and toggles the standard select in the middle of a frame.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} vid_std_e;

  localparam int unsigned S525_TOP_END  = 20;
  localparam int unsigned S525_MID_BEG  = 263;
  localparam int unsigned S525_MID_END  = 283;
  localparam int unsigned S525_LAST     = 525;
  localparam int unsigned S625_TOP_END  = 23;
  localparam int unsigned S625_MID_BEG  = 310;
  localparam int unsigned S625_MID_END  = 335;
  localparam int unsigned S625_TAIL_BEG = 623;
  localparam int unsigned S625_LAST     = 625;

  // Line 0 means "no frame start seen yet" and is always blanked.
  function automatic logic line_blanked(input int unsigned ln, input vid_std_e s);
    if (ln == 0) return 1'b1;
    if (s == STD_525)
      return (ln <= S525_TOP_END) ||
             (ln >= S525_MID_BEG && ln <= S525_MID_END) ||
             (ln == S525_LAST);
    return (ln <= S625_TOP_END) ||
           (ln >= S625_MID_BEG && ln <= S625_MID_END) ||
           (ln >= S625_TAIL_BEG && ln <= S625_LAST);
  endfunction
endpackage

// File: rtl/vbg_sync_edge.sv
module vbg_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic hsync_n,
  input  logic vsync_n,
  output logic hs_lead,
  output logic vs_lead,
  output logic hs_act
);
  logic hs_s, hs_d, vs_s, vs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_s <= 1'b1;
      hs_d <= 1'b1;
      vs_s <= 1'b1;
      vs_d <= 1'b1;
    end else begin
      hs_s <= hsync_n;
      hs_d <= hs_s;
      vs_s <= vsync_n;
      vs_d <= vs_s;
    end
  end

  assign hs_lead = hs_d & ~hs_s;
  assign vs_lead = vs_d & ~vs_s;
  assign hs_act  = ~hs_s;

  // R5
  hs_lead_single_chk: assert property (@(posedge clk) disable iff (rst)
    hs_lead |=> !hs_lead);
endmodule

// File: rtl/vbg_line_track.sv
module vbg_line_track
  import vbg_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_lead,
  input  logic              vs_lead,
  input  logic              hs_act,
  input  vid_std_e          std_in,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field_odd,
  output vid_std_e          std_q
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic vs_pend;
  logic restart;

  assign restart = hs_lead & (vs_pend | vs_lead);

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_pend   <= 1'b0;
      line_cnt  <= '0;
      field_odd <= 1'b0;
      std_q     <= STD_525;
    end else begin
      if (hs_lead)      vs_pend <= 1'b0;
      else if (vs_lead) vs_pend <= 1'b1;

      if (vs_lead) field_odd <= hs_act;

      if (restart) begin
        line_cnt <= LINE_W'(1);
        std_q    <= std_in;
      end else if (hs_lead && line_cnt != '0 && line_cnt != LINE_MAX) begin
        line_cnt <= line_cnt + LINE_W'(1);
      end
    end
  end

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_lead |=> $stable(line_cnt));
  // R7
  line_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_lead && vs_lead) |=> (line_cnt == LINE_W'(1)));
  // R8
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vs_lead |=> $stable(field_odd));
  // R9
  std_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_lead && (vs_lead || vs_pend)) |=> $stable(std_q));
endmodule

// File: rtl/vbg_bp_timer.sv
module vbg_bp_timer #(
  parameter int BP_CLKS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_lead,
  output logic bp_done
);
  localparam int CW = $clog2(BP_CLKS + 1);
  localparam logic [CW-1:0] BP_LOAD = CW'(BP_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (hs_lead)       cnt <= BP_LOAD;
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign bp_done = (cnt == '0);

  // R6
  bp_start_chk: assert property (@(posedge clk) disable iff (rst)
    hs_lead |=> !bp_done);
endmodule

// File: rtl/vid_blank_gen.sv
module vid_blank_gen
  import vbg_pkg::*;
#(
  parameter int LINE_W  = 10,
  parameter int BP_CLKS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_n,
  input  logic              vsync_n,
  input  logic              ext_blank_n,
  input  logic              pal_mode,
  output logic              field_odd,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              disp_en
);
  logic hs_lead, vs_lead, hs_act, bp_done, eb_q, vbl_now;
  vid_std_e std_q;

  vbg_sync_edge u_edge (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hs_lead(hs_lead), .vs_lead(vs_lead), .hs_act(hs_act)
  );

  vbg_line_track #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .hs_lead(hs_lead), .vs_lead(vs_lead),
    .hs_act(hs_act), .std_in(vid_std_e'(pal_mode)),
    .line_cnt(line_num), .field_odd(field_odd), .std_q(std_q)
  );

  vbg_bp_timer #(.BP_CLKS(BP_CLKS)) u_bp (
    .clk(clk), .rst(rst), .hs_lead(hs_lead), .bp_done(bp_done)
  );

  assign vbl_now = line_blanked(int'(line_num), std_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      eb_q    <= 1'b0;
      vblank  <= 1'b1;
      disp_en <= 1'b0;
    end else begin
      eb_q    <= ext_blank_n;
      vblank  <= vbl_now;
      disp_en <= eb_q & ~vbl_now & bp_done & ~hs_lead;
    end
  end

  // R1
  ext_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !eb_q |=> !disp_en);
  // R2
  excl_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !(vblank && disp_en));
  // R3
  first_line_chk: assert property (@(posedge clk) disable iff (rst)
    (line_num == LINE_W'(1)) |=> vblank);
  // R6
  sync_blank_chk: assert property (@(posedge clk) disable iff (rst)
    hs_lead |=> !disp_en);
endmodule

// File: tb/vid_blank_gen_test.sv
module vid_blank_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W   = 10;
  localparam int BP       = 6;
  localparam int LINE_LEN = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n = 1'b1, vsync_n = 1'b1, ext_blank_n = 1'b1, pal_mode = 1'b0;
  logic field_odd, vblank, disp_en;
  logic [LINE_W-1:0] line_num;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_blank_gen #(.LINE_W(LINE_W), .BP_CLKS(BP)) uut (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .ext_blank_n(ext_blank_n), .pal_mode(pal_mode),
    .field_odd(field_odd), .line_num(line_num), .vblank(vblank), .disp_en(disp_en)
  );

  function automatic bit exp_blank(int ln, bit pal);
    if (!pal) return (ln >= 1 && ln <= 20) || (ln >= 263 && ln <= 283) || ln == 525;
    return (ln >= 1 && ln <= 23) || (ln >= 310 && ln <= 335) || (ln >= 623 && ln <= 625);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One line: hsync low at start; optional vsync coincident (odd) or mid-line (even).
  task automatic run_line(int ln, bit pal, bit vs_odd, bit vs_even, bit flip_mode);
    int hw = 2 + (ln % 5);
    bit bl = exp_blank(ln, pal);
    @(negedge clk);
    hsync_n = 1'b0;
    if (vs_odd) vsync_n = 1'b0;
    for (int j = 1; j < LINE_LEN; j++) begin
      @(negedge clk);
      if (j == hw) hsync_n = 1'b1;
      if (j == 4 && vs_odd) vsync_n = 1'b1;
      if (j == 3 && flip_mode) pal_mode = ~pal;
      if (j == 2 + BP) chk("R6 porch blank", int'(disp_en), 0);
      if (j == 3 + BP) begin
        chk("R7 line_num", int'(line_num), ln);
        chk(pal ? "R4 vblank" : "R3 vblank", int'(vblank), int'(bl));
        chk("R2/R5 disp_en after porch", int'(disp_en), int'(!bl));
      end
      if (j == 12 && vs_even) vsync_n = 1'b0;
      if (j == 14) begin
        if (vs_even) vsync_n = 1'b1;
        ext_blank_n = 1'b0;
      end
      if (j == 16) begin
        chk("R1 ext blank low", int'(disp_en), 0);
        ext_blank_n = 1'b1;
      end
      if (j == 18) chk("R1 ext blank release", int'(disp_en), int'(!bl));
    end
  endtask

  task automatic run_frame(bit pal, bit start_odd, bit next_even);
    int nl = pal ? 625 : 525;
    @(negedge clk);
    pal_mode = pal;
    for (int ln = 1; ln <= nl; ln++) begin
      run_line(ln, pal, start_odd && ln == 1, next_even && ln == nl, ln == 100);
      if (ln == 2) chk("R8 field_odd", int'(field_odd), int'(start_odd));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 disp_en", int'(disp_en), 0);
    chk("R10 field_odd", int'(field_odd), 0);
    chk("R10 line_num", int'(line_num), 0);
    // R10 unlocked line stays blanked and unnumbered
    @(negedge clk); hsync_n = 1'b0;
    repeat (3) @(negedge clk); hsync_n = 1'b1;
    repeat (15) @(negedge clk);
    chk("R10 unlocked line_num", int'(line_num), 0);
    chk("R10 unlocked disp_en", int'(disp_en), 0);
    // R3 R4 R7 R8 R9: odd/even frames in both standards, mode flipped mid-frame
    run_frame(1'b0, 1'b1, 1'b1);
    run_frame(1'b0, 1'b0, 1'b0);
    run_frame(1'b1, 1'b1, 1'b1);
    run_frame(1'b1, 1'b0, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule